// File: doc/BRIEF.md
# DMA Channel Transfer-Mode Sequencer

This block sequences one channel of a small DMA controller. The channel has two control structures, primary and alternate. Each holds a 3-bit mode code and a 10-bit item count, and both live in a local register model that the host writes. When the channel starts a cycle, it reads the mode of the active structure and latches it. That mode then decides three things: whether each item transfer needs its own request, whether one request runs the whole count, and whether the channel moves to the other structure when the cycle ends.

Each item goes through the same handshake. The sequencer raises an arbitration request and holds it until it gets a grant. It then emits a one-clock transfer strobe and waits for a done pulse from the datapath. When the last item of a cycle finishes, the sequencer does three things at once: it pulses cycle-done, it writes the stop code back into the structure that just finished, and it either goes idle or fetches the other structure. Chaining to the other structure lets a host keep data moving without a gap: it refills one structure while the other is in use. The chain ends when the channel fetches a stopped structure, or one the host has set to a one-shot mode.

Top module: `dmach_mode_seq`

## Requirements
- R1: After the synchronous reset, arb_req, xfer_stb, cyc_done, wb_valid, alt_sel and err are all 0, and both structures hold mode 0 (stop).
- R2: Mode codes: 0 stop, 1 basic, 2 auto-request, 3 ping-pong, 4 memory scatter-gather (primary), 5 memory scatter-gather (alternate), 6 peripheral scatter-gather (primary), 7 peripheral scatter-gather (alternate). A request is ignored when the active structure holds stop, and no transfer takes place.
- R3: In basic mode (1), every item needs its own req pulse. No xfer_stb follows until that pulse arrives, and each strobe comes only after a cycle with arb_req and arb_gnt both high.
- R4: In auto-request mode (2), one req pulse moves every item of the cycle without any further request.
- R5: The count field holds the number of items minus one, so 0 gives exactly one item. The count is loaded when a cycle starts.
- R6: When the last item of a cycle completes, cyc_done and wb_valid pulse for one clock. wb_sel names the finished structure, and stop is written into that structure's mode, so a later request on it is ignored.
- R7: In ping-pong mode (3), each item needs a req pulse. When a cycle completes, alt_sel flips and the other structure is fetched and run in its own mode. Alternation continues for as long as the host reloads each structure after it finishes.
- R8: A chain ends when the fetched structure holds stop: the channel goes idle with alt_sel 0. If the fetched structure holds basic or auto-request, the channel runs that one cycle and then goes idle with alt_sel 0.
- R9: Code 5 or 7 in the primary structure, or code 4 or 6 in the alternate structure, is invalid. When such a structure is fetched, err is set, no transfer is made and the channel goes idle. err clears on the next host write.
- R10: A legal scatter-gather code runs one cycle and then chains to the other structure. Codes 4, 5 and 6 run without per-item requests. Code 7 needs a req pulse per item.
- R11: A req pulse that arrives while an item is waiting for a grant or is in flight is dropped, not queued. arb_req stays high until it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Single-cycle transfer request |
| host_we | input | 1 | Host write strobe for a control structure |
| host_sel | input | 1 | Structure written: 0 primary, 1 alternate |
| host_mode | input | 3 | Mode code written |
| host_cnt | input | CNT_W | Item count minus one written |
| arb_gnt | input | 1 | Arbitration grant |
| item_done | input | 1 | Datapath finished the current item |
| arb_req | output | 1 | Arbitration request for the next item |
| xfer_stb | output | 1 | One-clock strobe starting an item transfer |
| alt_sel | output | 1 | Active structure: 0 primary, 1 alternate |
| cyc_done | output | 1 | One-clock pulse at the end of a cycle |
| wb_valid | output | 1 | Stop code written back this clock |
| wb_sel | output | 1 | Structure receiving the write-back |
| err | output | 1 | Invalid scatter-gather placement seen |

## Verification
The assertions assume that the arbiter grants only while arb_req is high. They also assume that item_done pulses once per strobe and never before one. The bench meets both by driving arb_gnt as a copy of arb_req and item_done as a copy of xfer_stb, each sampled at the falling edge. The bench also sends each request pulse only after the previous item has settled, except where a request is deliberately dropped. Host writes go to a structure only while that structure is not the one being fetched.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_STOP  = 3'd0,
    MD_BASIC = 3'd1,
    MD_AUTO  = 3'd2,
    MD_PP    = 3'd3,
    MD_MSG_P = 3'd4,
    MD_MSG_A = 3'd5,
    MD_PSG_P = 3'd6,
    MD_PSG_A = 3'd7
  } md_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_ARB, S_BUSY
  } st_e;

  // Scatter-gather code sitting in the wrong structure
  function automatic logic md_misplaced(input logic [MODE_W-1:0] m, input logic alt);
    return (alt && (m == MD_MSG_P || m == MD_PSG_P)) ||
           (!alt && (m == MD_MSG_A || m == MD_PSG_A));
  endfunction

  // Each item needs its own request
  function automatic logic md_per_req(input logic [MODE_W-1:0] m);
    return (m == MD_BASIC) || (m == MD_PP) || (m == MD_PSG_A);
  endfunction

  // Cycle end moves to the other structure
  function automatic logic md_chains(input logic [MODE_W-1:0] m);
    return (m == MD_PP) || (m == MD_MSG_P) || (m == MD_MSG_A) ||
           (m == MD_PSG_P) || (m == MD_PSG_A);
  endfunction
endpackage

// File: rtl/dmach_ctl_store.sv
module dmach_ctl_store
  import dmach_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [MODE_W-1:0] host_mode,
  input  logic [CNT_W-1:0]  host_cnt,
  input  logic              wb_we,
  input  logic              wb_sel,
  input  logic              rd_sel,
  output logic [MODE_W-1:0] rd_mode,
  output logic [CNT_W-1:0]  rd_cnt
);
  localparam int NSTRUCT = 2;

  logic [NSTRUCT*MODE_W-1:0] mode_flat;
  logic [NSTRUCT*CNT_W-1:0]  cnt_flat;

  for (genvar g = 0; g < NSTRUCT; g++) begin : g_struct
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q <= MD_STOP;
        cnt_q  <= '0;
      end else if (host_we && (int'(host_sel) == g)) begin
        mode_q <= host_mode;          // host write wins over write-back
        cnt_q  <= host_cnt;
      end else if (wb_we && (int'(wb_sel) == g)) begin
        mode_q <= MD_STOP;
      end
    end
    assign mode_flat[g*MODE_W +: MODE_W] = mode_q;
    assign cnt_flat[g*CNT_W +: CNT_W]    = cnt_q;
  end

  assign rd_mode = mode_flat[int'(rd_sel)*MODE_W +: MODE_W];
  assign rd_cnt  = cnt_flat[int'(rd_sel)*CNT_W +: CNT_W];
endmodule

// File: rtl/dmach_item_ctr.sv
module dmach_item_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/dmach_mode_seq.sv
module dmach_mode_seq
  import dmach_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [MODE_W-1:0] host_mode,
  input  logic [CNT_W-1:0]  host_cnt,
  input  logic              arb_gnt,
  input  logic              item_done,
  output logic              arb_req,
  output logic              xfer_stb,
  output logic              alt_sel,
  output logic              cyc_done,
  output logic              wb_valid,
  output logic              wb_sel,
  output logic              err
);
  st_e               st;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] rd_mode;
  logic [CNT_W-1:0]  rd_cnt;
  logic              last;
  logic              bad, runnable, start, fin, ctr_load, ctr_dec;

  dmach_ctl_store #(.CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_sel(host_sel), .host_mode(host_mode), .host_cnt(host_cnt),
    .wb_we(fin), .wb_sel(alt_sel),
    .rd_sel(alt_sel), .rd_mode(rd_mode), .rd_cnt(rd_cnt)
  );

  dmach_item_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst),
    .load(ctr_load), .load_val(rd_cnt), .dec(ctr_dec), .last(last)
  );

  // Fetch-time decode of the active structure
  assign bad      = md_misplaced(rd_mode, alt_sel);
  assign runnable = !bad && (rd_mode != MD_STOP);
  assign start    = ((st == S_IDLE) && req) || (st == S_FETCH);
  assign ctr_load = start && runnable;
  assign fin      = (st == S_BUSY) && item_done && last;
  assign ctr_dec  = (st == S_BUSY) && item_done && !last;
  assign arb_req  = (st == S_ARB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mode_q   <= MD_STOP;
      alt_sel  <= 1'b0;
      xfer_stb <= 1'b0;
      cyc_done <= 1'b0;
      wb_valid <= 1'b0;
      wb_sel   <= 1'b0;
      err      <= 1'b0;
    end else begin
      xfer_stb <= 1'b0;
      cyc_done <= 1'b0;
      wb_valid <= 1'b0;
      if (host_we) err <= 1'b0;
      if (start && bad) err <= 1'b1;

      unique case (st)
        S_IDLE: begin
          if (req && runnable) begin
            mode_q <= rd_mode;
            st     <= S_ARB;          // this request covers the first item
          end
        end
        S_FETCH: begin
          if (runnable) begin
            mode_q <= rd_mode;
            st     <= md_per_req(rd_mode) ? S_WAIT : S_ARB;
          end else begin
            alt_sel <= 1'b0;
            st      <= S_IDLE;
          end
        end
        S_WAIT: if (req) st <= S_ARB;
        S_ARB: begin
          if (arb_gnt) begin
            xfer_stb <= 1'b1;
            st       <= S_BUSY;
          end
        end
        S_BUSY: begin
          if (item_done) begin
            if (last) begin
              cyc_done <= 1'b1;
              wb_valid <= 1'b1;
              wb_sel   <= alt_sel;
              if (md_chains(mode_q)) begin
                alt_sel <= ~alt_sel;
                st      <= S_FETCH;
              end else begin
                alt_sel <= 1'b0;
                st      <= S_IDLE;
              end
            end else begin
              st <= md_per_req(mode_q) ? S_WAIT : S_ARB;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmach_mode_seq_chk.sv
module dmach_mode_seq_chk (
  input logic clk,
  input logic rst,
  input logic arb_req,
  input logic arb_gnt,
  input logic xfer_stb,
  input logic alt_sel,
  input logic cyc_done,
  input logic wb_valid,
  input logic wb_sel,
  input logic err
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!xfer_stb && !arb_req && !err && !alt_sel && !cyc_done));

  p_stb_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> $past(arb_req && arb_gnt));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done);

  p_wb_names_finished_r6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_sel == $past(alt_sel)));

  p_sel_moves_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(alt_sel) |-> (cyc_done || $past(cyc_done)));

  p_err_no_stb_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !xfer_stb);

  p_arb_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (arb_req && !arb_gnt) |=> arb_req);
endmodule

bind dmach_mode_seq dmach_mode_seq_chk u_chk (.*);

// File: tb/dmach_mode_seq_tb.sv
`timescale 1ns/1ps
module dmach_mode_seq_tb;
  localparam int CNT_W = 10;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0;
  logic host_we = 1'b0, host_sel = 1'b0;
  logic [2:0] host_mode = '0;
  logic [CNT_W-1:0] host_cnt = '0;
  logic arb_gnt = 1'b0, item_done = 1'b0;
  logic arb_req, xfer_stb, alt_sel, cyc_done, wb_valid, wb_sel, err;

  int checks = 0, fails = 0, n_stb = 0;
  int exp_q[$];
  logic err_d = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmach_mode_seq #(.CNT_W(CNT_W)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected event encoding: kind*2 + structure; kind 0 strobe, 1 done, 2 err
  task automatic push_stb(input int sel, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(sel);
  endtask
  task automatic push_done(input int sel); exp_q.push_back(2 + sel); endtask
  task automatic push_err(); exp_q.push_back(4); endtask

  task automatic pop_cmp(input int got, input string tag);
    int e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " unexpected event"}, got, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e == got, tag, got, e);
    end
  endtask

  // Monitor and datapath/arbiter stub
  always @(negedge clk) begin
    if (!rst) begin
      if (xfer_stb) begin n_stb++; pop_cmp(int'(alt_sel), "R3/R4/R7 strobe"); end
      if (cyc_done) begin
        pop_cmp(2 + int'(wb_sel), "R6 cycle end");
        chk(wb_valid, "R6 write-back with done", int'(wb_valid), 1);
      end
      if (err && !err_d) pop_cmp(4, "R9 error");
    end
    err_d     = err;
    arb_gnt   = arb_req;
    item_done = xfer_stb;
  end

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic host_wr(input logic sel, input logic [2:0] m, input int c);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_mode = m; host_cnt = CNT_W'(c);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!arb_req, "R1 arb_req", int'(arb_req), 0);
    chk(!xfer_stb, "R1 xfer_stb", int'(xfer_stb), 0);
    chk(!alt_sel, "R1 alt_sel", int'(alt_sel), 0);
    chk(!err && !cyc_done && !wb_valid, "R1 err/done", int'(err), 0);

    // R2 stopped structure ignores request
    pulse_req(); idle(10);
    chk(n_stb == 0, "R2 stop ignores req", n_stb, 0);

    // R3 basic, 3 items, one request each
    host_wr(1'b0, 3'd1, 2);
    push_stb(0, 3); push_done(0);
    base = n_stb;
    pulse_req(); idle(20);
    chk(n_stb - base == 1, "R3 one item per request", n_stb - base, 1);
    pulse_req(); idle(20);
    pulse_req(); idle(20);
    chk(n_stb - base == 3, "R3 three items", n_stb - base, 3);
    // R6 structure now stopped
    pulse_req(); idle(15);
    chk(n_stb - base == 3, "R6 stop written back", n_stb - base, 3);

    // R11 request during a pending item dropped
    host_wr(1'b0, 3'd1, 1);
    push_stb(0, 2); push_done(0);
    base = n_stb;
    pulse_req(); pulse_req(); idle(20);
    chk(n_stb - base == 1, "R11 request dropped", n_stb - base, 1);
    pulse_req(); idle(20);
    chk(exp_q.size() == 0, "R11 cycle finished", exp_q.size(), 0);

    // R4 auto, 5 items from one request
    host_wr(1'b0, 3'd2, 4);
    push_stb(0, 5); push_done(0);
    base = n_stb;
    pulse_req(); idle(60);
    chk(n_stb - base == 5, "R4 auto full count", n_stb - base, 5);

    // R5 count 0 means one item
    host_wr(1'b0, 3'd2, 0);
    push_stb(0, 1); push_done(0);
    base = n_stb;
    pulse_req(); idle(20);
    chk(n_stb - base == 1, "R5 single item", n_stb - base, 1);

    // R7 ping-pong alternation with reload
    host_wr(1'b0, 3'd3, 1);
    host_wr(1'b1, 3'd3, 0);
    push_stb(0, 2); push_done(0); push_stb(1, 1); push_done(1);
    push_stb(0, 1); push_done(0);
    pulse_req(); idle(20); pulse_req(); idle(20);
    chk(alt_sel == 1'b1, "R7 switched to alternate", int'(alt_sel), 1);
    host_wr(1'b0, 3'd3, 0);
    pulse_req(); idle(20);
    chk(alt_sel == 1'b0, "R7 back to primary", int'(alt_sel), 0);
    pulse_req(); idle(20);
    // R8 alternate was stopped: chain ends
    chk(alt_sel == 1'b0 && exp_q.size() == 0, "R8 chain ends on stop", exp_q.size(), 0);

    // R8 host-set auto in the other structure ends chain after one cycle
    host_wr(1'b0, 3'd3, 0);
    host_wr(1'b1, 3'd2, 1);
    push_stb(0, 1); push_done(0); push_stb(1, 2); push_done(1);
    pulse_req(); idle(40);
    chk(exp_q.size() == 0, "R8 auto ends chain", exp_q.size(), 0);
    chk(alt_sel == 1'b0, "R8 idle on primary", int'(alt_sel), 0);

    // R9 misplaced scatter-gather code
    host_wr(1'b0, 3'd5, 3);
    push_err();
    base = n_stb;
    pulse_req(); idle(10);
    chk(err == 1'b1, "R9 err set", int'(err), 1);
    chk(n_stb == base, "R9 no transfer", n_stb - base, 0);
    host_wr(1'b0, 3'd0, 0);
    idle(2);
    chk(err == 1'b0, "R9 err cleared by write", int'(err), 0);

    // R10 legal scatter-gather chain: primary 4 auto, alternate 7 per request
    host_wr(1'b0, 3'd4, 1);
    host_wr(1'b1, 3'd7, 0);
    push_stb(0, 2); push_done(0); push_stb(1, 1); push_done(1);
    base = n_stb;
    pulse_req(); idle(30);
    chk(n_stb - base == 2 && alt_sel == 1'b1, "R10 primary then alternate wait", n_stb - base, 2);
    pulse_req(); idle(20);
    chk(exp_q.size() == 0 && alt_sel == 1'b0, "R10 chain complete", exp_q.size(), 0);

    chk(exp_q.size() == 0, "R6 all events seen", exp_q.size(), 0);
    finished = 1'b1;
    summary();
  end
endmodule